// File: doc/BRIEF.md
# Prioritized Outbound Address Window Translator

This block turns a local-bus address into a PCI bus address using three programmable windows. Two general windows can be set to any power-of-two size from 1 MB to 2 GB, and one I/O window has a fixed 16 MB span. Every window is described by a base register (position, size, enable, prefetch) and a map register (replacement upper address bits, cycle type, low-bit handling).

A lookup is purely combinational. For the address presented, every enabled window is compared at once, and the lowest-numbered window that matches supplies the result. The result is the translated address, the PCI cycle type, the prefetch flag, and a miss flag when nothing matches. Because overlapping windows resolve by number, software can enlarge window 0 to cover window 1, reprogram window 1 while it is hidden (for example as a configuration aperture), and then shrink window 0 again.

The six window registers are loaded through a one-cycle write port. A write takes effect from the next rising clock edge.

Top module: `owt_xlate`

## Requirements
- R1: After reset every window is disabled, so every lookup reports a miss.
- R2: General window i (0 or 1) matches when its base bit 0 is set and the local address agrees with base bits 31:20 above the size boundary. The size code in base bits 7:4 gives a size of 1 MB shifted left by the code.
- R3: On a general-window hit, PCI address bits at and above the size boundary come from map bits 15:4 (placed at PCI bits 31:20). The local offset below the boundary is kept.
- R4: Size codes 12 to 15 behave exactly like code 11 (2 GB).
- R5: A window whose enable bit is clear never matches, whatever its other fields hold.
- R6: When several windows match, the lowest-numbered one (0, then 1, then the I/O window 2) supplies every output.
- R7: The cycle type output equals map bits 3:1 of the winning general window (0 interrupt acknowledge, 1 I/O, 3 memory, 5 configuration, 6 memory-multiple). The I/O window always reports 1.
- R8: The prefetch output equals base bit 3 of the winning general window. It is 0 for the I/O window.
- R9: For a general window, PCI address bits 1:0 copy the local address when map bit 0 is 1, and are 0 otherwise.
- R10: The I/O window matches when its base bit 0 is set and local bits 31:24 equal its base bits 15:8. The translated address is map bits 15:8 followed by local bits 23:0.
- R11: On a miss the miss output is 1 and the address, cycle type and prefetch outputs are all 0.
- R12: The write select codes are 0 base0, 1 map0, 2 base1, 3 map1, 4 base2, 5 map2. Map registers and the I/O base take data bits 15:0. Select codes 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code (see R12) |
| wr_data | input | 32 | Register write data |
| lb_addr | input | 32 | Local-bus address to translate |
| pci_addr | output | 32 | Translated PCI address |
| cyc_type | output | 3 | PCI cycle type of the winning window |
| prefetch | output | 1 | Prefetchable flag of the winning window |
| miss | output | 1 | No enabled window matched |

## Verification
Every size code from 0 to 15 is swept on window 0. Each code is probed at the first and last byte inside the window and at the bytes just outside it, which separates a correct boundary from an off-by-one mask and shows that codes 12 to 15 clamp to 2 GB. Overlap tests enlarge and then shrink window 0 across window 1, and disable window 0 outright. These tests show that the lowest-numbered window wins rather than the last one or a merge of both. Separate patterns check low-bit forcing against pass-through, I/O window translation next to a hit in a general window, writes to unused select codes, and a run of random addresses against a mixed configuration.

// File: rtl/owt_pkg.sv
`timescale 1ns/1ps
package owt_pkg;
  localparam int unsigned MAP_REG_W = 16;
  localparam int unsigned IO_REG_W  = 16;
  localparam logic [2:0]  CYC_IO    = 3'd1;

  // Size code clamped to the largest legal code.
  function automatic int unsigned clamp_code(input logic [3:0] code,
                                             input int unsigned max_code);
    int unsigned c;
    c = {28'd0, code};
    return (c > max_code) ? max_code : c;
  endfunction

  // Mask of the offset bits below a size boundary at bit position sh.
  function automatic logic [63:0] offset_mask(input int unsigned sh);
    if (sh >= 64) return '1;
    return (64'd1 << sh) - 64'd1;
  endfunction
endpackage

// File: rtl/owt_regs.sv
`timescale 1ns/1ps
module owt_regs
  import owt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_MEM = 2,
  parameter int SEL_W   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [SEL_W-1:0]                     wr_sel,
  input  logic [ADDR_W-1:0]                    wr_data,
  output logic [NUM_MEM-1:0][ADDR_W-1:0]       base_mem_q,
  output logic [NUM_MEM-1:0][MAP_REG_W-1:0]    map_mem_q,
  output logic [IO_REG_W-1:0]                  base_io_q,
  output logic [IO_REG_W-1:0]                  map_io_q
);
  localparam int IO_BASE_SEL = 2 * NUM_MEM;
  localparam int IO_MAP_SEL  = 2 * NUM_MEM + 1;

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_mem_q[i] <= '0;
        map_mem_q[i]  <= '0;
      end else if (wr_en) begin
        if (wr_sel == SEL_W'(2 * i))     base_mem_q[i] <= wr_data;
        if (wr_sel == SEL_W'(2 * i + 1)) map_mem_q[i]  <= wr_data[MAP_REG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_io_q <= '0;
      map_io_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_W'(IO_BASE_SEL)) base_io_q <= wr_data[IO_REG_W-1:0];
      if (wr_sel == SEL_W'(IO_MAP_SEL))  map_io_q  <= wr_data[IO_REG_W-1:0];
    end
  end
endmodule

// File: rtl/owt_mem_win.sv
`timescale 1ns/1ps
module owt_mem_win
  import owt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MIN_SHIFT = 20,
  parameter int MAX_CODE  = 11,
  parameter int MAP_LSB   = 4
) (
  input  logic [ADDR_W-1:0]    base_q,
  input  logic [MAP_REG_W-1:0] map_q,
  input  logic [ADDR_W-1:0]    lb_addr,
  output logic                 hit,
  output logic [ADDR_W-1:0]    addr,
  output logic [2:0]           cyc,
  output logic                 pf
);
  localparam int FIELD_W = ADDR_W - MIN_SHIFT;

  int unsigned       shift_amt;
  logic [63:0]       mask_wide;
  logic [ADDR_W-1:0] keep_low;
  logic [ADDR_W-1:0] map_full;
  logic [ADDR_W-1:0] raw_addr;

  always_comb begin
    shift_amt = MIN_SHIFT + clamp_code(base_q[7:4], MAX_CODE);
    mask_wide = offset_mask(shift_amt);
    keep_low  = mask_wide[ADDR_W-1:0];
    map_full  = {map_q[MAP_LSB +: FIELD_W], {MIN_SHIFT{1'b0}}};
    hit       = base_q[0] && ((lb_addr & ~keep_low) == (base_q & ~keep_low));
    raw_addr  = (map_full & ~keep_low) | (lb_addr & keep_low);
    addr      = {raw_addr[ADDR_W-1:2], map_q[0] ? lb_addr[1:0] : 2'b00};
    cyc       = map_q[3:1];
    pf        = base_q[3];
  end

  logic unused_base_bits;
  assign unused_base_bits = ^{base_q[MIN_SHIFT-1:8], base_q[2:1], mask_wide[63:ADDR_W]};
endmodule

// File: rtl/owt_io_win.sv
`timescale 1ns/1ps
module owt_io_win
  import owt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_SHIFT = 24
) (
  input  logic [IO_REG_W-1:0] base_q,
  input  logic [IO_REG_W-1:0] map_q,
  input  logic [ADDR_W-1:0]   lb_addr,
  output logic                hit,
  output logic [ADDR_W-1:0]   addr,
  output logic [2:0]          cyc,
  output logic                pf
);
  localparam int FIELD_W = ADDR_W - IO_SHIFT;

  always_comb begin
    hit  = base_q[0] &&
           (lb_addr[ADDR_W-1 -: FIELD_W] == base_q[IO_REG_W-1 -: FIELD_W]);
    addr = {map_q[IO_REG_W-1 -: FIELD_W], lb_addr[IO_SHIFT-1:0]};
    cyc  = CYC_IO;
    pf   = 1'b0;
  end

  logic unused_io_bits;
  assign unused_io_bits = ^{base_q[IO_REG_W-FIELD_W-1:1], map_q[IO_REG_W-FIELD_W-1:0]};
endmodule

// File: rtl/owt_prio.sv
`timescale 1ns/1ps
module owt_prio #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3
) (
  input  logic [NUM_WIN-1:0]             hit_vec,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_addr,
  input  logic [NUM_WIN-1:0][2:0]        win_cyc,
  input  logic [NUM_WIN-1:0]             win_pf,
  output logic [NUM_WIN-1:0]             sel_vec,
  output logic [ADDR_W-1:0]              out_addr,
  output logic [2:0]                     out_cyc,
  output logic                           out_pf,
  output logic                           out_miss
);
  logic taken;

  always_comb begin
    taken   = 1'b0;
    sel_vec = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_vec[i] && !taken) begin
        sel_vec[i] = 1'b1;
        taken      = 1'b1;
      end
    end
    out_addr = '0;
    out_cyc  = '0;
    out_pf   = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      out_addr = out_addr | (win_addr[i] & {ADDR_W{sel_vec[i]}});
      out_cyc  = out_cyc  | (win_cyc[i]  & {3{sel_vec[i]}});
      out_pf   = out_pf   | (win_pf[i] & sel_vec[i]);
    end
    out_miss = !taken;
  end
endmodule

// File: rtl/owt_xlate.sv
`timescale 1ns/1ps
module owt_xlate
  import owt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_MEM   = 2,
  parameter int MIN_SHIFT = 20,
  parameter int MAX_CODE  = 11,
  parameter int IO_SHIFT  = 24,
  localparam int NUM_WIN  = NUM_MEM + 1,
  localparam int SEL_W    = $clog2(2 * NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] lb_addr,
  output logic [ADDR_W-1:0] pci_addr,
  output logic [2:0]        cyc_type,
  output logic              prefetch,
  output logic              miss
);
  logic [NUM_MEM-1:0][ADDR_W-1:0]    base_mem_q;
  logic [NUM_MEM-1:0][MAP_REG_W-1:0] map_mem_q;
  logic [IO_REG_W-1:0]               base_io_q;
  logic [IO_REG_W-1:0]               map_io_q;

  logic [NUM_WIN-1:0]             hit_vec;
  logic [NUM_WIN-1:0]             sel_vec;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_addr;
  logic [NUM_WIN-1:0][2:0]        win_cyc;
  logic [NUM_WIN-1:0]             win_pf;

  owt_regs #(.ADDR_W(ADDR_W), .NUM_MEM(NUM_MEM), .SEL_W(SEL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .base_mem_q (base_mem_q),
    .map_mem_q  (map_mem_q),
    .base_io_q  (base_io_q),
    .map_io_q   (map_io_q)
  );

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem_win
    owt_mem_win #(.ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE)) u_win (
      .base_q  (base_mem_q[i]),
      .map_q   (map_mem_q[i]),
      .lb_addr (lb_addr),
      .hit     (hit_vec[i]),
      .addr    (win_addr[i]),
      .cyc     (win_cyc[i]),
      .pf      (win_pf[i])
    );
  end

  owt_io_win #(.ADDR_W(ADDR_W), .IO_SHIFT(IO_SHIFT)) u_io_win (
    .base_q  (base_io_q),
    .map_q   (map_io_q),
    .lb_addr (lb_addr),
    .hit     (hit_vec[NUM_WIN-1]),
    .addr    (win_addr[NUM_WIN-1]),
    .cyc     (win_cyc[NUM_WIN-1]),
    .pf      (win_pf[NUM_WIN-1])
  );

  owt_prio #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_prio (
    .hit_vec  (hit_vec),
    .win_addr (win_addr),
    .win_cyc  (win_cyc),
    .win_pf   (win_pf),
    .sel_vec  (sel_vec),
    .out_addr (pci_addr),
    .out_cyc  (cyc_type),
    .out_pf   (prefetch),
    .out_miss (miss)
  );
endmodule

// File: rtl/owt_xlate_chk.sv
`timescale 1ns/1ps
module owt_xlate_chk
  import owt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_MEM = 2,
  localparam int NUM_WIN = NUM_MEM + 1,
  localparam int SEL_W   = $clog2(2 * NUM_WIN)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              wr_en,
  input logic [SEL_W-1:0]                  wr_sel,
  input logic [ADDR_W-1:0]                 pci_addr,
  input logic [2:0]                        cyc_type,
  input logic                              prefetch,
  input logic                              miss,
  input logic [NUM_WIN-1:0]                hit_vec,
  input logic [NUM_WIN-1:0]                sel_vec,
  input logic [NUM_MEM-1:0][ADDR_W-1:0]    base_mem_q,
  input logic [NUM_MEM-1:0][MAP_REG_W-1:0] map_mem_q,
  input logic [IO_REG_W-1:0]               base_io_q,
  input logic [IO_REG_W-1:0]               map_io_q
);
  assert_miss_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (pci_addr == '0 && cyc_type == 3'd0 && !prefetch));

  assert_single_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec) && (miss == (sel_vec == '0)));

  assert_first_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] |-> sel_vec[0]);

  assert_hit_not_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> !miss);

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_en
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !base_mem_q[i][0] |-> !hit_vec[i]);
  end

  assert_io_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !base_io_q[0] |-> !hit_vec[NUM_WIN-1]);

  assert_io_attrs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vec[NUM_WIN-1] |-> (cyc_type == 3'd1 && !prefetch));

  assert_bad_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel >= SEL_W'(2 * NUM_WIN)) |=>
      ($stable(base_mem_q) && $stable(map_mem_q) && $stable(base_io_q) && $stable(map_io_q)));
endmodule

bind owt_xlate owt_xlate_chk #(.ADDR_W(ADDR_W), .NUM_MEM(NUM_MEM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .pci_addr   (pci_addr),
  .cyc_type   (cyc_type),
  .prefetch   (prefetch),
  .miss       (miss),
  .hit_vec    (hit_vec),
  .sel_vec    (sel_vec),
  .base_mem_q (base_mem_q),
  .map_mem_q  (map_mem_q),
  .base_io_q  (base_io_q),
  .map_io_q   (map_io_q)
);

// File: tb/owt_xlate_test.sv
`timescale 1ns/1ps
module owt_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] lb_addr = '0;
  logic [31:0] pci_addr;
  logic [2:0]  cyc_type;
  logic        prefetch;
  logic        miss;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  logic [31:0] sh_base [2];
  logic [15:0] sh_map  [2];
  logic [15:0] sh_base2;
  logic [15:0] sh_map2;

  owt_xlate uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lb_addr(lb_addr), .pci_addr(pci_addr), .cyc_type(cyc_type),
    .prefetch(prefetch), .miss(miss)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      summary();
    end
  end

  // Register write with shadow copy; codes per R12.
  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      3'd0: sh_base[0] = data;
      3'd1: sh_map[0]  = data[15:0];
      3'd2: sh_base[1] = data;
      3'd3: sh_map[1]  = data[15:0];
      3'd4: sh_base2   = data[15:0];
      3'd5: sh_map2    = data[15:0];
      default: ;
    endcase
  endtask

  // Reference translation, stated as block/offset arithmetic.
  task automatic model(input logic [31:0] a, output logic [31:0] ea,
                       output logic [2:0] ec, output logic epf, output logic emiss);
    longint unsigned la, sz, blk;
    int code;
    bit found;
    found = 1'b0;
    ea = '0; ec = '0; epf = 1'b0; emiss = 1'b1;
    la = {32'd0, a};
    for (int w = 0; w < 2; w++) begin
      if (!found && sh_base[w][0]) begin
        code = int'({28'd0, sh_base[w][7:4]});
        if (code > 11) code = 11;
        sz = 64'd1 << (20 + code);
        if ((la / sz) == ({32'd0, sh_base[w]} / sz)) begin
          found = 1'b1;
          blk = ({52'd0, sh_map[w][15:4]} * 64'h100000) / sz * sz;
          ea = 32'(blk + (la % sz));
          if (!sh_map[w][0]) ea = ea - (ea % 4);
          ec = sh_map[w][3:1];
          epf = sh_base[w][3];
          emiss = 1'b0;
        end
      end
    end
    if (!found && sh_base2[0] && (la / 64'h1000000) == {56'd0, sh_base2[15:8]}) begin
      ea = 32'({56'd0, sh_map2[15:8]} * 64'h1000000 + (la % 64'h1000000));
      ec = 3'd1; epf = 1'b0; emiss = 1'b0;
    end
  endtask

  task automatic lookup(input logic [31:0] a, input string tag);
    logic [31:0] ea; logic [2:0] ec; logic epf, emiss;
    lb_addr = a;
    #1;
    model(a, ea, ec, epf, emiss);
    checks++;
    if (pci_addr !== ea || cyc_type !== ec || prefetch !== epf || miss !== emiss) begin
      errors++;
      $display("FAIL %s lb=%h actual addr=%h cyc=%0d pf=%0b miss=%0b expected addr=%h cyc=%0d pf=%0b miss=%0b",
               tag, a, pci_addr, cyc_type, prefetch, miss, ea, ec, epf, emiss);
    end
  endtask

  task automatic t_reset();
    lookup(32'h0000_0000, "R1 reset");
    lookup(32'h4000_0000, "R1 reset");
    lookup(32'hFFFF_FFFF, "R11 reset miss");
  endtask

  task automatic t_basic();
    wr_reg(3'd0, 32'h4000_0081);          // 256 MB at 0x4000_0000
    wr_reg(3'd1, 32'h0000_1236);          // map 0x123, memory type, low bits forced
    lookup(32'h4567_89AB, "R3 R7 R9 basic");
    lookup(32'h4000_0000, "R2 first byte");
    lookup(32'h4FFF_FFFF, "R2 last byte");
    lookup(32'h5000_0000, "R11 past window");
    wr_reg(3'd1, 32'h0000_123B);          // config type 5, pass low bits
    lookup(32'h4567_89AB, "R9 R7 pass low");
  endtask

  task automatic t_sizes();
    for (int c = 0; c < 16; c++) begin
      logic [31:0] b;
      longint unsigned sz;
      int cc;
      cc = (c > 11) ? 11 : c;
      sz = 64'd1 << (20 + cc);
      b = 32'h8000_0001 | (32'(c) << 4);
      wr_reg(3'd0, b);
      lookup(32'h8000_0000, "R2 R4 size first");
      lookup(32'(64'h8000_0000 + sz - 1), "R2 R4 size last");
      lookup(32'(64'h8000_0000 + sz), "R2 R4 size past");
      lookup(32'h7FFF_FFFF, "R2 size below");
    end
  endtask

  task automatic t_priority();
    wr_reg(3'd0, 32'h4000_0091);          // 512 MB covering 0x5...
    wr_reg(3'd1, 32'h0000_0006);
    wr_reg(3'd2, 32'h5000_0049);          // 16 MB prefetchable
    wr_reg(3'd3, 32'h0000_ABCB);
    lookup(32'h5000_1234, "R6 window0 hides window1");
    wr_reg(3'd0, 32'h4000_0081);          // shrink to 256 MB
    lookup(32'h5000_1234, "R6 R8 window1 revealed");
    wr_reg(3'd0, 32'h4000_0090);          // disabled
    lookup(32'h4100_0000, "R5 disabled miss");
    lookup(32'h5000_0010, "R5 disabled falls to window1");
  endtask

  task automatic t_io();
    wr_reg(3'd4, 32'hFFFF_6001);
    wr_reg(3'd5, 32'h0000_AB00);
    lookup(32'h6012_3457, "R10 io hit");
    lookup(32'h6100_0000, "R10 io past");
    lookup(32'h5FFF_FFFF, "R10 io below");
    wr_reg(3'd2, 32'h6000_0001);          // 1 MB general window over io
    lookup(32'h6000_0003, "R6 general beats io");
    lookup(32'h6010_0003, "R6 io after general");
    wr_reg(3'd4, 32'h0000_6000);
    lookup(32'h6020_0000, "R5 io disabled");
  endtask

  task automatic t_bad_sel();
    wr_reg(3'd4, 32'h0000_6001);
    wr_reg(3'd6, 32'hFFFF_FFFF);
    wr_reg(3'd7, 32'h0000_0000);
    lookup(32'h6020_0000, "R12 ignored select io");
    lookup(32'h5000_0010, "R12 ignored select mem");
    lookup(32'h4000_0000, "R12 ignored select miss");
  endtask

  task automatic t_random();
    wr_reg(3'd0, 32'h2000_00A9);          // 1 GB at 0, prefetch
    wr_reg(3'd1, 32'h0000_C007);
    wr_reg(3'd2, 32'h0000_00B1);          // 2 GB overlapping
    wr_reg(3'd3, 32'h0000_700C);
    for (int k = 0; k < 40; k++) lookup($urandom, "R2 R3 R6 random");
  endtask

  initial begin
    for (int w = 0; w < 2; w++) begin sh_base[w] = '0; sh_map[w] = '0; end
    sh_base2 = '0; sh_map2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_sizes();
    t_priority();
    t_io();
    t_bad_sel();
    t_random();
    done_flag = 1'b1;
    summary();
  end
endmodule